// File: doc/BRIEF.md
# Status Flag Mask-Clear Executor

This block carries out the flag-clearing instruction of a small processor core. The 16-bit instruction word holds an operation code in its upper byte and an eight-bit clear mask in its lower byte. When the code matches, every flag the mask selects is cleared in a single commit. The eight mask bits are spread over two 16-bit status registers, four flags in each. The instruction lasts one cycle, or two when the mask touches either of the two flags that gate interrupts and debug events.

The instruction cannot be repeated. A repeat count loaded just before it by a repeat instruction is forced to zero when the instruction is accepted, and the clear runs only once. The repeat count is loaded through a separate load strobe. The core sees the two status registers, the repeat count and a one-cycle done pulse that marks completion.

Top module: `flag_clear_exec`

## Requirements
- R1: An instruction is accepted only when `instr_valid_i` is high, bits 15:8 of `instr_i` equal 0x29, and no two-cycle instruction is in flight. Any other word leaves the status registers and the repeat count unchanged and raises no done pulse.
- R2: Mask bit i (i = 0..3) clears bit i of `st0_o`. In bit order from 0, these are sign-extension mode, overflow mode, test/control and carry.
- R3: Mask bit 4+i (i = 0..3) clears bit i of `st1_o`. In bit order from 0, these are interrupt mask, debug mask, page-zero addressing and vector map.
- R4: Flags whose mask bit is zero, and bits 15:4 of both status registers, never change.
- R5: When mask bit 4 or 5 is set, the instruction takes two cycles. `done_o` is low in the cycle after acceptance and high in the cycle after that. The flags change on the same edge that raises `done_o`.
- R6: Any other accepted mask takes one cycle. The flags change on the accepting edge, and `done_o` is high for exactly the following cycle.
- R7: Acceptance sets `rpt_cnt_o` to zero on the accepting edge. This wins over a repeat load in the same cycle, and each accepted instruction gives exactly one done pulse.
- R8: A zero mask is accepted. It takes one cycle, changes no flag, clears the repeat count and pulses `done_o`.
- R9: A valid word that arrives in the second cycle of a two-cycle instruction is ignored.
- R10: With `rst_ni` low, `st0_o` = 0xA00F, `st1_o` = 0x5A0F, `rpt_cnt_o` = 0 and `done_o` = 0.
- R11: When no instruction is accepted, `rpt_load_i` loads `rpt_val_i` into the repeat count on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction word valid strobe |
| instr_i | input | 16 | Instruction word: code in bits 15:8, mask in bits 7:0 |
| rpt_load_i | input | 1 | Load strobe for the repeat count |
| rpt_val_i | input | 16 | Repeat count value to load |
| st0_o | output | 16 | First status register |
| st1_o | output | 16 | Second status register |
| rpt_cnt_o | output | 16 | Repeat count |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two things can happen in the same cycle: a repeat-count load and the acceptance of a clear instruction. A third overlap occurs when a new valid word arrives while the second cycle of a slow clear is still pending. The bench drives a load in the same cycle as acceptance, and also a valid word in the hold cycle of an interrupt-mask clear. It judges each result against a behavioural model that gives the clear priority over the load and ignores the late word. Every output is compared on every clock.

// File: rtl/fcx_pkg.sv
package fcx_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned OP_W    = 8;
  localparam int unsigned MASK_W  = 8;
  localparam int unsigned FLAG_N  = 4;
  localparam int unsigned BANK_N  = MASK_W / FLAG_N;
  localparam int unsigned STAT_W  = 16;

  localparam logic [OP_W-1:0]   OP_CLRF  = 8'h29;
  // mask bits that stretch the instruction to two cycles
  localparam logic [MASK_W-1:0] SLOW_SEL = 8'h30;

  typedef struct packed {
    logic              hit;
    logic              slow;
    logic [MASK_W-1:0] mask;
  } dec_t;

  typedef enum logic {SQ_IDLE, SQ_HOLD} sq_e;
endpackage

// File: rtl/fcx_decode.sv
module fcx_decode
  import fcx_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [OP_W-1:0]   op;
  logic [MASK_W-1:0] mask;

  assign op   = instr_i[INSTR_W-1 -: OP_W];
  assign mask = instr_i[MASK_W-1:0];

  always_comb begin
    dec_o.hit  = (op == OP_CLRF);
    dec_o.mask = mask;
    dec_o.slow = |(mask & SLOW_SEL);
  end
endmodule

// File: rtl/fcx_seq.sv
module fcx_seq
  import fcx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  dec_t              dec_i,
  output logic              accept_o,
  output logic              commit_o,
  output logic [MASK_W-1:0] commit_mask_o,
  output logic              busy_o,
  output logic              done_o
);
  sq_e               state_q, state_d;
  logic [MASK_W-1:0] mask_q;
  logic              done_q;

  assign busy_o   = (state_q == SQ_HOLD);
  assign accept_o = req_i & dec_i.hit & ~busy_o;
  assign commit_o = (accept_o & ~dec_i.slow) | busy_o;
  assign commit_mask_o = busy_o ? mask_q : dec_i.mask;

  always_comb begin
    state_d = SQ_IDLE;
    if (accept_o && dec_i.slow) state_d = SQ_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) mask_q <= dec_i.mask;
      done_q  <= commit_o;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/fcx_stat_reg.sv
module fcx_stat_reg #(
  parameter int unsigned   W   = 16,
  parameter int unsigned   N   = 4,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] mask_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b < N) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                q[b] <= RST[b];
        else if (clr_i && mask_i[b]) q[b] <= 1'b0;
      end
    end else begin : g_keep
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[b] <= RST[b];
      end
    end
  end

  assign q_o = q;
endmodule

// File: rtl/fcx_rpt.sv
module fcx_rpt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  // clear from an accepted instruction wins over a load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (ld_i)  cnt_q <= val_i;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/flag_clear_exec.sv
module flag_clear_exec
  import fcx_pkg::*;
#(
  parameter int unsigned        RPT_W   = 16,
  parameter logic [STAT_W-1:0]  ST0_RST = 16'hA00F,
  parameter logic [STAT_W-1:0]  ST1_RST = 16'h5A0F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               rpt_load_i,
  input  logic [RPT_W-1:0]   rpt_val_i,
  output logic [STAT_W-1:0]  st0_o,
  output logic [STAT_W-1:0]  st1_o,
  output logic [RPT_W-1:0]   rpt_cnt_o,
  output logic               done_o
);
  localparam logic [BANK_N-1:0][STAT_W-1:0] BANK_RST = {ST1_RST, ST0_RST};

  dec_t              dec;
  logic              accept;
  logic              commit;
  logic [MASK_W-1:0] commit_mask;
  logic              busy;
  logic [STAT_W-1:0] st_q [BANK_N];

  fcx_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  fcx_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (instr_valid_i),
    .dec_i         (dec),
    .accept_o      (accept),
    .commit_o      (commit),
    .commit_mask_o (commit_mask),
    .busy_o        (busy),
    .done_o        (done_o)
  );

  for (genvar g = 0; g < BANK_N; g++) begin : g_bank
    fcx_stat_reg #(
      .W   (STAT_W),
      .N   (FLAG_N),
      .RST (BANK_RST[g])
    ) u_st (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (commit),
      .mask_i (commit_mask[g*FLAG_N +: FLAG_N]),
      .q_o    (st_q[g])
    );
  end

  fcx_rpt #(.W(RPT_W)) u_rpt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .ld_i   (rpt_load_i),
    .val_i  (rpt_val_i),
    .cnt_o  (rpt_cnt_o)
  );

  assign st0_o = st_q[0];
  assign st1_o = st_q[1];
endmodule

// File: rtl/fcx_chk.sv
module fcx_chk
  import fcx_pkg::*;
#(
  parameter int unsigned RPT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               instr_valid_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic               busy,
  input logic               done_o,
  input logic [STAT_W-1:0]  st0_o,
  input logic [STAT_W-1:0]  st1_o,
  input logic [RPT_W-1:0]   rpt_cnt_o
);
  logic acc_w;
  assign acc_w = instr_valid_i && (instr_i[15:8] == OP_CLRF) && !busy;

  // R1
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !acc_w |=> !done_o);

  // R4
  st_upper_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($stable(st0_o[15:4]) && $stable(st1_o[15:4])));

  // R2
  st0_only_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((st0_o[3:0] & ~$past(st0_o[3:0])) == 4'h0));

  // R3
  st1_only_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((st1_o[3:0] & ~$past(st1_o[3:0])) == 4'h0));

  // R5
  slow_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_w && (instr_i[4] || instr_i[5]) |=> !done_o ##1 done_o);

  // R6
  fast_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_w && !(instr_i[4] || instr_i[5]) |=> done_o);

  // R7
  rpt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_w |=> (rpt_cnt_o == '0));

  // R9
  hold_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> !busy);
endmodule

bind flag_clear_exec fcx_chk #(.RPT_W(RPT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_i       (instr_i),
  .busy          (busy),
  .done_o        (done_o),
  .st0_o         (st0_o),
  .st1_o         (st1_o),
  .rpt_cnt_o     (rpt_cnt_o)
);

// File: tb/sim_flag_clear_exec.sv
`timescale 1ns/1ps
module sim_flag_clear_exec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        rpt_load_i = 1'b0;
  logic [15:0] rpt_val_i = '0;
  logic [15:0] st0_o, st1_o, rpt_cnt_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  int cyc_n  = 0;
  string cur_tag = "R10";

  // behavioural reference state
  logic [15:0] m_st0, m_st1, m_rpt;
  logic        m_done;
  logic        m_pend;
  logic [7:0]  m_pmask;

  always #10 clk_i = ~clk_i;

  flag_clear_exec u0 (
    .clk_i, .rst_ni, .instr_valid_i, .instr_i,
    .rpt_load_i, .rpt_val_i, .st0_o, .st1_o, .rpt_cnt_o, .done_o
  );

  function automatic void apply(input logic [7:0] m);
    for (int i = 0; i < 4; i++) begin
      if (m[i])   m_st0[i] = 1'b0;
      if (m[i+4]) m_st1[i] = 1'b0;
    end
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st0 = 16'hA00F; m_st1 = 16'h5A0F; m_rpt = '0;
      m_done = 1'b0; m_pend = 1'b0; m_pmask = '0;
    end else begin
      logic took;
      took = 1'b0;
      m_done = 1'b0;
      if (m_pend) begin
        apply(m_pmask);
        m_done = 1'b1;
        m_pend = 1'b0;
      end else if (instr_valid_i && instr_i[15:8] == 8'h29) begin
        took = 1'b1;
        m_rpt = '0;
        if (instr_i[4] || instr_i[5]) begin
          m_pend = 1'b1;
          m_pmask = instr_i[7:0];
        end else begin
          apply(instr_i[7:0]);
          m_done = 1'b1;
        end
      end
      if (!took && rpt_load_i) m_rpt = rpt_val_i;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc_n++;
    if (cyc_n > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cyc_n);
      summary();
    end
  end

  task automatic compare();
    checks++;
    if (st0_o !== m_st0 || st1_o !== m_st1 || rpt_cnt_o !== m_rpt || done_o !== m_done) begin
      fails++;
      $display("FAIL %s: actual st0=%h st1=%h rpt=%h done=%b, expected st0=%h st1=%h rpt=%h done=%b",
               cur_tag, st0_o, st1_o, rpt_cnt_o, done_o, m_st0, m_st1, m_rpt, m_done);
    end
  endtask

  // compare the previous cycle's result, then drive the next cycle
  task automatic cyc(input logic v, input logic [15:0] w, input logic ld,
                     input logic [15:0] val, input string tag);
    @(negedge clk_i);
    compare();
    instr_valid_i = v; instr_i = w; rpt_load_i = ld; rpt_val_i = val;
    cur_tag = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0000, 1'b0, 16'h0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    instr_valid_i = 1'b0; rpt_load_i = 1'b0;
    @(negedge clk_i);
    cur_tag = "R10";
    compare();
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset();
    idle(2, "R10");
    // R2: first-register flags
    cyc(1, 16'h2901, 0, 0, "R2");
    cyc(1, 16'h290A, 0, 0, "R2");
    idle(1, "R6");
    cyc(1, 16'h290F, 0, 0, "R2");
    idle(2, "R4");
    // R3: second-register flags, fast and slow
    do_reset();
    cyc(1, 16'h2940, 0, 0, "R3");
    cyc(1, 16'h2980, 0, 0, "R3");
    cyc(1, 16'h2910, 0, 0, "R5");
    idle(3, "R5");
    cyc(1, 16'h2921, 0, 0, "R5");
    idle(3, "R5");
    // R1: wrong opcodes and invalid strobe
    do_reset();
    cyc(1, 16'h28FF, 0, 0, "R1");
    cyc(1, 16'h39FF, 0, 0, "R1");
    cyc(0, 16'h29FF, 0, 0, "R1");
    idle(2, "R1");
    // R11 and R7: load then collide with an accept
    cyc(0, 16'h0, 1, 16'h0005, "R11");
    idle(1, "R11");
    cyc(1, 16'h2902, 1, 16'h0007, "R7");
    idle(2, "R7");
    cyc(0, 16'h0, 1, 16'h0009, "R11");
    cyc(1, 16'h2900, 0, 0, "R8");
    idle(2, "R8");
    // R9: valid word in the hold cycle is ignored, load there still lands
    do_reset();
    cyc(1, 16'h2930, 0, 0, "R9");
    cyc(1, 16'h2901, 1, 16'h0033, "R9");
    idle(3, "R9");
    // R4: single bits, upper bits untouched
    do_reset();
    for (int i = 0; i < 8; i++) cyc(1, 16'h2900 | (16'h1 << i), 0, 0, "R4");
    idle(3, "R4");
    // back-to-back slow ops with a repeat load pending
    do_reset();
    cyc(0, 16'h0, 1, 16'h00AA, "R11");
    cyc(1, 16'h2920, 0, 0, "R7");
    cyc(1, 16'h2910, 0, 0, "R9");
    cyc(1, 16'h2910, 0, 0, "R5");
    idle(3, "R5");
    summary();
  end
endmodule